// File: doc/BRIEF.md
# Processor condition-flag register

This block holds the eight-bit status word of a small processor core. After each ALU operation it takes the two operands, the result the ALU produced and a two-bit operation class, and from those it derives the carry, zero, negative, overflow, sign and half-carry flags. The new values are registered, so they appear on the output on the clock edge that ends the operation. An operation of the "no update" class leaves the word as it is.

Two more bits ride in the same byte. One is a transfer bit: a bit-store request loads it from a single data bit, and the bit-load path can read it through its own output. The other is a global interrupt enable, which gates a vector of pending interrupt requests. Software can overwrite the whole byte, or it can set or clear one bit chosen by index. Nothing is saved or restored automatically around interrupt entry or exit, so that task belongs to software.

Top module: `status_flag_reg`

## Requirements
- R1: The flag byte has this layout: bit 7 is the interrupt enable, bit 6 the transfer bit, bit 5 half carry, bit 4 sign, bit 3 overflow, bit 2 negative, bit 1 zero and bit 0 carry. Synchronous reset clears all eight bits.
- R2: The operation class is encoded as 0 for no update, 1 for add, 2 for subtract and 3 for logic. On an add, carry is set when the unsigned sum exceeds 255. On a subtract, carry is set when the unsigned first operand is smaller than the second, which is a borrow.
- R3: For add, subtract and logic, zero is set exactly when the eight-bit result is 0x00.
- R4: For add, subtract and logic, negative is set equal to bit 7 of the result.
- R5: Overflow is set on an add when both operands have the same sign and the result's sign differs from it. It is set on a subtract when the operands' signs differ and the result's sign differs from the first operand's. A logic operation clears it.
- R6: Sign is set to negative XOR overflow for every updating class. For example, 0x78 + 0x0A gives overflow 1, negative 1 and sign 0.
- R7: Half carry is set on an add when the low nibbles sum to more than 15. For example, 0x0D + 0x15 sets it and 0x16 + 0x16 does not. It is set on a subtract when the first operand's low nibble is smaller than the second's.
- R8: A logic operation leaves carry and half carry at their previous values.
- R9: With the no-update class and no other write, the whole byte keeps its value.
- R10: A bit-store request loads the transfer bit from the supplied data bit, and the transfer-bit output always shows bit 6 of the byte.
- R11: A single-bit write puts the supplied value in the bit chosen by its 3-bit index. In the same cycle it overrides an ALU update or a bit-store for that bit only, and the other bits update normally.
- R12: A whole-byte write takes priority over every other update in the same cycle.
- R13: The interrupt output is high only when bit 7 of the byte is 1 and at least one pending request is high. While bit 7 is 0 it stays low, whatever the requests are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_cls | input | 2 | Operation class: 0 none, 1 add, 2 subtract, 3 logic |
| opnd_a | input | 8 | First ALU operand |
| opnd_b | input | 8 | Second ALU operand |
| alu_res | input | 8 | ALU result for the operation |
| bst_en | input | 1 | Load the transfer bit |
| bst_bit | input | 1 | Data bit for the transfer bit |
| bit_mod_en | input | 1 | Single-bit write strobe |
| bit_mod_val | input | 1 | Value for the single-bit write |
| bit_sel | input | 3 | Index of the bit to write |
| wr_en | input | 1 | Whole-byte write strobe |
| wr_data | input | 8 | Byte for the whole-byte write |
| irq_pend | input | 4 | Pending interrupt requests |
| flags | output | 8 | Registered flag byte |
| irq_take | output | 1 | Gated interrupt request |
| t_bit | output | 1 | Transfer bit for the bit-load path |

## Verification
Additions are tried with operand pairs chosen so that the flags can be told apart. Signed overflow without carry (0x78 + 0x0A) separates sign from negative. Wrap to zero with carry (0xFF + 0x01) and two negatives wrapping to zero (0x80 + 0x80) each raise a distinct set of flags, and the nibble pairs from R7 separate half carry from full carry. Subtractions cover a borrow through every bit, a signed overflow with no borrow, and a nibble-only borrow. Logic results show that carry and half carry are kept while overflow is cleared. A sweep of 64 generated operand pairs across all three classes then checks the whole byte, and further cycles pit a whole-byte write and a single-bit write against an ALU update that arrives in the same cycle.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

    localparam int FLAG_W = 8;
    localparam int SEL_W  = $clog2(FLAG_W);

    localparam int POS_C = 0;
    localparam int POS_Z = 1;
    localparam int POS_N = 2;
    localparam int POS_V = 3;
    localparam int POS_S = 4;
    localparam int POS_H = 5;
    localparam int POS_T = 6;
    localparam int POS_I = 7;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ADD   = 2'd1,
        CLS_SUB   = 2'd2,
        CLS_LOGIC = 2'd3
    } op_cls_e;

    // field order is the bit order of the flag byte, msb first
    typedef struct packed {
        logic ien;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } flag_byte_t;

    // carry out of a bit position for an add, from the operand and result bits
    function automatic logic add_carry(input logic a, input logic b, input logic r);
        return (a & b) | (b & ~r) | (~r & a);
    endfunction

    // borrow out of a bit position for a subtract
    function automatic logic sub_borrow(input logic a, input logic b, input logic r);
        return (~a & b) | (b & r) | (r & ~a);
    endfunction

    function automatic logic add_ovf(input logic a, input logic b, input logic r);
        return (a & b & ~r) | (~a & ~b & r);
    endfunction

    function automatic logic sub_ovf(input logic a, input logic b, input logic r);
        return (a & ~b & ~r) | (~a & b & r);
    endfunction

endpackage

// File: rtl/sflag_calc.sv
module sflag_calc
    import sflag_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_cls_e          cls,
    input  logic [DW-1:0]    opnd_a,
    input  logic [DW-1:0]    opnd_b,
    input  logic [DW-1:0]    res,
    input  flag_byte_t       cur,
    output flag_byte_t       nxt,
    output logic             upd
);
    localparam int MSB = DW - 1;
    localparam int HB  = DW / 2 - 1;

    logic am, bm, rm, ah, bh, rh;

    assign am = opnd_a[MSB];
    assign bm = opnd_b[MSB];
    assign rm = res[MSB];
    assign ah = opnd_a[HB];
    assign bh = opnd_b[HB];
    assign rh = res[HB];

    assign upd = (cls != CLS_NONE);

    always_comb begin
        nxt = cur;
        unique case (cls)
            CLS_ADD: begin
                nxt.c = add_carry(am, bm, rm);
                nxt.h = add_carry(ah, bh, rh);
                nxt.v = add_ovf(am, bm, rm);
            end
            CLS_SUB: begin
                nxt.c = sub_borrow(am, bm, rm);
                nxt.h = sub_borrow(ah, bh, rh);
                nxt.v = sub_ovf(am, bm, rm);
            end
            CLS_LOGIC: begin
                nxt.v = 1'b0;
            end
            default: ;
        endcase
        if (cls != CLS_NONE) begin
            nxt.z = (res == '0);
            nxt.n = rm;
            nxt.s = rm ^ nxt.v;
        end
    end

endmodule

// File: rtl/sflag_store.sv
module sflag_store
    import sflag_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  flag_byte_t         alu_nxt,
    input  logic               alu_upd,
    input  logic               bst_en,
    input  logic               bst_bit,
    input  logic               bit_mod_en,
    input  logic               bit_mod_val,
    input  logic [SEL_W-1:0]   bit_sel,
    input  logic               wr_en,
    input  logic [FLAG_W-1:0]  wr_data,
    output flag_byte_t         flag_q
);
    flag_byte_t          stage_alu;
    logic [FLAG_W-1:0]   stage_bits;
    logic [FLAG_W-1:0]   stage_mod;
    logic [FLAG_W-1:0]   flag_d;

    always_comb begin
        stage_alu = alu_upd ? alu_nxt : flag_q;
        if (bst_en) begin
            stage_alu.t = bst_bit;
        end
    end

    assign stage_bits = stage_alu;

    for (genvar i = 0; i < FLAG_W; i++) begin : g_bitmod
        assign stage_mod[i] = (bit_mod_en && (bit_sel == SEL_W'(i))) ? bit_mod_val
                                                                     : stage_bits[i];
    end

    assign flag_d = wr_en ? wr_data : stage_mod;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    // R9
    no_update_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!alu_upd && !bst_en && !bit_mod_en && !wr_en) |=> $stable(flag_q));

    // R12
    byte_write_prio_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (flag_q == $past(wr_data)));

    // R10
    bst_loads_t_chk: assert property (@(posedge clk) disable iff (rst)
        (bst_en && !wr_en && !(bit_mod_en && bit_sel == SEL_W'(POS_T)))
        |=> (flag_q.t == $past(bst_bit)));

    // R11
    bit_mod_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_mod_en && !wr_en) |=> (flag_q[$past(bit_sel)] == $past(bit_mod_val)));

    // R6
    sign_xor_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_upd && !wr_en && !bit_mod_en) |=> (flag_q.s == (flag_q.n ^ flag_q.v)));

endmodule

// File: rtl/sflag_irq_gate.sv
module sflag_irq_gate #(
    parameter int NIRQ = 4
) (
    input  logic             ien,
    input  logic [NIRQ-1:0]  pend,
    output logic             take
);
    assign take = ien & (|pend);
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
    import sflag_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NIRQ = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         op_cls,
    input  logic [DW-1:0]      opnd_a,
    input  logic [DW-1:0]      opnd_b,
    input  logic [DW-1:0]      alu_res,
    input  logic               bst_en,
    input  logic               bst_bit,
    input  logic               bit_mod_en,
    input  logic               bit_mod_val,
    input  logic [2:0]         bit_sel,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    input  logic [NIRQ-1:0]    irq_pend,
    output logic [7:0]         flags,
    output logic               irq_take,
    output logic               t_bit
);
    localparam int MSB = DW - 1;

    op_cls_e     cls;
    flag_byte_t  cur_q;
    flag_byte_t  alu_nxt;
    logic        alu_upd;

    assign cls = op_cls_e'(op_cls);

    sflag_calc #(.DW(DW)) u_calc (
        .cls    (cls),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .res    (alu_res),
        .cur    (cur_q),
        .nxt    (alu_nxt),
        .upd    (alu_upd)
    );

    sflag_store u_store (
        .clk         (clk),
        .rst         (rst),
        .alu_nxt     (alu_nxt),
        .alu_upd     (alu_upd),
        .bst_en      (bst_en),
        .bst_bit     (bst_bit),
        .bit_mod_en  (bit_mod_en),
        .bit_mod_val (bit_mod_val),
        .bit_sel     (bit_sel),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .flag_q      (cur_q)
    );

    sflag_irq_gate #(.NIRQ(NIRQ)) u_gate (
        .ien  (cur_q.ien),
        .pend (irq_pend),
        .take (irq_take)
    );

    assign flags = cur_q;
    assign t_bit = cur_q.t;

    // R13
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        !flags[POS_I] |-> !irq_take);

    // R3
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (op_cls != 2'd0 && !wr_en && !bit_mod_en)
        |=> (flags[POS_Z] == ($past(alu_res) == '0)));

    // R4
    neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (op_cls != 2'd0 && !wr_en && !bit_mod_en)
        |=> (flags[POS_N] == $past(alu_res[MSB])));

    // R8
    logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (op_cls == 2'd3 && !wr_en && !bit_mod_en)
        |=> ($stable(flags[POS_C]) && $stable(flags[POS_H]) && !flags[POS_V]));

endmodule

// File: tb/test_status_flag_reg.sv
module test_status_flag_reg;

    localparam int CLK_PERIOD = 10;
    localparam int NIRQ = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       op_cls = '0;
    logic [7:0]       opnd_a = '0, opnd_b = '0, alu_res = '0;
    logic             bst_en = 1'b0, bst_bit = 1'b0;
    logic             bit_mod_en = 1'b0, bit_mod_val = 1'b0;
    logic [2:0]       bit_sel = '0;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = '0;
    logic [NIRQ-1:0]  irq_pend = '0;
    logic [7:0]       flags;
    logic             irq_take;
    logic             t_bit;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    int         due_q[$];
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] model = '0;

    status_flag_reg #(.DW(8), .NIRQ(NIRQ)) i_status_flag_reg (
        .clk(clk), .rst(rst), .op_cls(op_cls), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .alu_res(alu_res), .bst_en(bst_en), .bst_bit(bst_bit),
        .bit_mod_en(bit_mod_en), .bit_mod_val(bit_mod_val), .bit_sel(bit_sel),
        .wr_en(wr_en), .wr_data(wr_data), .irq_pend(irq_pend),
        .flags(flags), .irq_take(irq_take), .t_bit(t_bit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: compares each expected byte in the cycle it is due
    always @(negedge clk) begin
        while (due_q.size() > 0 && due_q[0] == cyc) begin
            check(tag_q[0], flags, exp_q[0]);
            check({tag_q[0], " R10 t_bit"}, {7'd0, t_bit}, {7'd0, exp_q[0][6]});
            void'(due_q.pop_front());
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    // bench reference of the flag byte, written from the requirements
    function automatic logic [7:0] ref_next(
        input logic [7:0] cur, input logic [1:0] cls,
        input logic [7:0] a, input logic [7:0] b, input logic [7:0] r,
        input logic be, input logic bb, input logic me, input logic mv,
        input logic [2:0] sel, input logic we, input logic [7:0] wd);
        logic [7:0] f;
        logic [8:0] sum9;
        f = cur;
        if (cls == 2'd1) begin
            sum9 = {1'b0, a} + {1'b0, b};
            f[0] = sum9[8];
            f[5] = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
            f[3] = (a[7] == b[7]) && (r[7] != a[7]);
        end else if (cls == 2'd2) begin
            f[0] = a < b;
            f[5] = a[3:0] < b[3:0];
            f[3] = (a[7] != b[7]) && (r[7] != a[7]);
        end else if (cls == 2'd3) begin
            f[3] = 1'b0;
        end
        if (cls != 2'd0) begin
            f[1] = (r == 8'h00);
            f[2] = r[7];
            f[4] = f[2] ^ f[3];
        end
        if (be) f[6] = bb;
        if (me) f[sel] = mv;
        if (we) f = wd;
        return f;
    endfunction

    // driver: applies one cycle of stimulus and queues the expected byte
    task automatic drive(input string tag, input logic [1:0] cls,
                         input logic [7:0] a, input logic [7:0] b, input logic [7:0] r,
                         input logic be = 0, input logic bb = 0,
                         input logic me = 0, input logic mv = 0, input logic [2:0] sel = 0,
                         input logic we = 0, input logic [7:0] wd = 0);
        @(negedge clk);
        op_cls = cls; opnd_a = a; opnd_b = b; alu_res = r;
        bst_en = be; bst_bit = bb; bit_mod_en = me; bit_mod_val = mv; bit_sel = sel;
        wr_en = we; wr_data = wd;
        model = ref_next(model, cls, a, b, r, be, bb, me, mv, sel, we, wd);
        due_q.push_back(cyc + 1);
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        drive("R9 idle", 2'd0, 8'h00, 8'h00, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        irq_pend = '1;
        @(negedge clk);
        check("R1 reset byte", flags, 8'h00);
        check("R13 reset gate", {7'd0, irq_take}, 8'h00);

        // R6 signed overflow: V=1 N=1 S=0, no carry, H from 8+A
        drive("R6 add 78+0A", 2'd1, 8'h78, 8'h0A, 8'h82);
        drive("R7 add 0D+15 half", 2'd1, 8'h0D, 8'h15, 8'h22);
        drive("R7 add 16+16 no half", 2'd1, 8'h16, 8'h16, 8'h2C);
        drive("R2 R3 add FF+01", 2'd1, 8'hFF, 8'h01, 8'h00);
        drive("R5 add 80+80", 2'd1, 8'h80, 8'h80, 8'h00);
        drive("R2 sub 00-01 borrow", 2'd2, 8'h00, 8'h01, 8'hFF);
        drive("R5 sub 80-01 ovf", 2'd2, 8'h80, 8'h01, 8'h7F);
        drive("R7 sub 10-01 half borrow", 2'd2, 8'h10, 8'h01, 8'h0F);
        drive("R4 sub 05-05 zero", 2'd2, 8'h05, 8'h05, 8'h00);
        // set C and H, then a logic op must keep them and clear V
        drive("R2 add F8+18", 2'd1, 8'hF8, 8'h18, 8'h10);
        drive("R5 add 7F+01", 2'd1, 8'h7F, 8'h01, 8'h80);
        drive("R8 logic keeps C H", 2'd3, 8'hF0, 8'h0F, 8'h00);
        drive("R8 logic neg", 2'd3, 8'h90, 8'hF0, 8'h90);
        idle();
        idle();
        drive("R10 bst 1", 2'd0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1);
        drive("R10 bst with add", 2'd1, 8'h01, 8'h01, 8'h02, 1'b1, 1'b0);
        drive("R11 set I over add", 2'd1, 8'h01, 8'h02, 8'h03, 1'b0, 1'b0, 1'b1, 1'b1, 3'd7);
        drive("R11 clear Z over add", 2'd1, 8'hFF, 8'h01, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1);
        drive("R11 set T over bst", 2'd0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 3'd6);
        drive("R12 byte write over all", 2'd1, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b0,
              1'b1, 1'b1, 3'd0, 1'b1, 8'h5A);
        drive("R12 byte write I set", 2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0,
              1'b0, 1'b0, 3'd0, 1'b1, 8'h80);
        @(negedge clk);
        irq_pend = 4'b0100;
        #1;
        check("R13 gate open", {7'd0, irq_take}, 8'h01);
        irq_pend = 4'b0000;
        #1;
        check("R13 no request", {7'd0, irq_take}, 8'h00);
        drive("R11 clear I", 2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd7);
        @(negedge clk);
        irq_pend = '1;
        #1;
        check("R13 gate masked", {7'd0, irq_take}, 8'h00);

        // sweep of generated operand pairs over all updating classes
        for (int i = 0; i < 64; i++) begin
            logic [7:0] a, b, r;
            logic [1:0] c;
            a = 8'(i * 37 + 5);
            b = 8'(i * 91 + 200);
            c = 2'(1 + (i % 3));
            r = (c == 2'd1) ? a + b : (c == 2'd2) ? a - b : (a ^ b);
            drive("R2 R5 R6 R7 sweep", c, a, b, r);
        end
        idle();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule